// File: doc/BRIEF.md
# Exception Cause Register Write Unit

This block holds a 32-bit exception cause register and applies software writes to it. A write changes only the bits in a writable mask. The mask is formed from a fixed base set and is widened or narrowed by two architecture-revision inputs. Every other bit keeps its old value. The hardware interrupt pending bits, the trap-written exception code and the counter itself are handled elsewhere. Here those bits simply never change.

After each write the unit compares the old value with the new one and produces side effects:

- A change to the disable-count bit moves a two-state count controller between running and halted. This starts or stops the free-running counter's enable.
- A change to either software interrupt pending bit drives the matching request line to the new level.

The count controller has two states:

- **CNT_RUN**: the count enable is high.
- **CNT_HALT**: the count enable is low.

It has two transitions:

- **STOP** (CNT_RUN to CNT_HALT): a write moves the disable-count bit from 0 to 1.
- **START** (CNT_HALT to CNT_RUN): a write moves the disable-count bit from 1 to 0.

Top module: `cause_wr_unit`

## Requirements
- R1: While reset is held and on its release, the register reads 0, `count_en` is 1 and `soft_irq` is 0.
- R2: With both revision inputs low, a write changes only bits 8, 9, 22 and 23 (mask 0x00C00300), and bit 22 takes the written value. Every other bit stays as it was. The new value appears on `cause_q` one cycle after the write.
- R3: With `rev2_en` high, bit 27 (disable-count) is also writable. With `rev2_en` low, bit 27 is never changed by a write.
- R4: With `rev6_en` high, writing 0 to bit 22 (watchpoint pending) clears it, and writing 1 to it leaves it unchanged.
- R5: When a write changes bit 27 from 0 to 1, `count_en` is 0 from the cycle in which the new value is visible (STOP). When a write changes it from 1 to 0, `count_en` returns to 1 in that same cycle (START).
- R6: When a write changes bit 8 or bit 9, `soft_irq[0]` or `soft_irq[1]` respectively takes the new bit level in the cycle the new value is visible.
- R7: A write that leaves bits 27, 8 and 9 unchanged leaves `count_en` and `soft_irq` unchanged.
- R8: With `wr_en` low, `cause_q`, `count_en` and `soft_irq` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value offered by the write |
| rev2_en | input | 1 | Revision-2 feature: makes disable-count writable |
| rev6_en | input | 1 | Revision-6 feature: makes watchpoint bit clear-only |
| cause_q | output | 32 | Current register value |
| count_en | output | 1 | Enable for the free-running counter |
| soft_irq | output | 2 | Software interrupt request lines |

## Verification
The hardest state to reach is a write that sets the watchpoint bit while `rev6_en` is high. A 1 can only get into that bit through a write made while `rev6_en` is low. So the stimulus first sets bit 22 with the revision input low, then raises `rev6_en` and writes both 1 and 0. The STOP and START transitions also need `rev2_en` high during the toggling write. The random phase therefore draws the revision inputs separately on each write and biases `wr_data` so that bits 27, 9 and 8 flip often.

// File: rtl/cause_pkg.sv
package cause_pkg;
    parameter int unsigned REG_W    = 32;
    parameter int unsigned IRQ_N    = 2;
    parameter int unsigned DC_BIT   = 27;
    parameter int unsigned WP_BIT   = 22;
    parameter int unsigned IP_LSB   = 8;
    parameter logic [REG_W-1:0] BASE_MASK = 32'h00C0_0300;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_HALT = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/cause_mask_gen.sv
module cause_mask_gen
    import cause_pkg::*;
(
    input  logic [REG_W-1:0] wr_data,
    input  logic             rev2_en,
    input  logic             rev6_en,
    output logic [REG_W-1:0] wr_mask
);
    localparam logic [REG_W-1:0] DC_ONE = REG_W'(1) << DC_BIT;
    localparam logic [REG_W-1:0] WP_ONE = REG_W'(1) << WP_BIT;

    always_comb begin
        wr_mask = BASE_MASK;
        if (rev2_en) begin
            wr_mask = wr_mask | DC_ONE;
        end
        if (rev6_en) begin
            // watchpoint: a written 1 is dropped from the mask, a 0 still clears
            wr_mask = wr_mask & ~(WP_ONE & wr_data);
        end
    end
endmodule

// File: rtl/cause_count_fsm.sv
module cause_count_fsm
    import cause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic dc_old,
    input  logic dc_new,
    output logic count_en
);
    cnt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_RUN:  if (wr_en && !dc_old && dc_new) state_d = CNT_HALT; // STOP
            CNT_HALT: if (wr_en && dc_old && !dc_new) state_d = CNT_RUN;  // START
            default:  state_d = CNT_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        count_en = (state_q == CNT_RUN);
    end

    a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dc_old && dc_new) |=> !count_en);
    a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dc_old && !dc_new) |=> count_en);
    a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_old == dc_new) |=> $stable(count_en));
endmodule

// File: rtl/cause_swirq.sv
module cause_swirq
    import cause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IRQ_N-1:0] ip_old,
    input  logic [IRQ_N-1:0] ip_new,
    output logic [IRQ_N-1:0] soft_irq
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                soft_irq[i] <= 1'b0;
            end else if (wr_en && (ip_old[i] != ip_new[i])) begin
                soft_irq[i] <= ip_new[i];
            end
        end

        a_r6_line: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && ip_old[i] != ip_new[i]) |=> (soft_irq[i] == $past(ip_new[i])));
        a_r7_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (ip_old[i] == ip_new[i]) |=> $stable(soft_irq[i]));
    end
endmodule

// File: rtl/cause_wr_unit.sv
module cause_wr_unit
    import cause_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rev2_en,
    input  logic        rev6_en,
    output logic [31:0] cause_q,
    output logic        count_en,
    output logic [1:0]  soft_irq
);
    localparam logic [REG_W-1:0] EVER_WRITABLE = BASE_MASK | (REG_W'(1) << DC_BIT);

    logic [REG_W-1:0] wr_mask;
    logic [REG_W-1:0] cause_r;
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] cause_nx;

    cause_mask_gen u_mask (
        .wr_data (wr_data),
        .rev2_en (rev2_en),
        .rev6_en (rev6_en),
        .wr_mask (wr_mask)
    );

    always_comb begin
        merged   = (cause_r & ~wr_mask) | (wr_data & wr_mask);
        cause_nx = wr_en ? merged : cause_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_r <= '0;
        else        cause_r <= cause_nx;
    end

    cause_count_fsm u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .dc_old   (cause_r[DC_BIT]),
        .dc_new   (cause_nx[DC_BIT]),
        .count_en (count_en)
    );

    cause_swirq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .ip_old   (cause_r[IP_LSB +: IRQ_N]),
        .ip_new   (cause_nx[IP_LSB +: IRQ_N]),
        .soft_irq (soft_irq)
    );

    assign cause_q = cause_r;

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~EVER_WRITABLE) == '0));
    a_r3_dc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rev2_en) |=> $stable(cause_q[DC_BIT]));
    a_r4_wp_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rev6_en && !cause_q[WP_BIT]) |=> !cause_q[WP_BIT]);
    a_r5_cnt_tracks_dc: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_en == !cause_q[DC_BIT]));
    a_r6_irq_tracks_ip: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (soft_irq == cause_q[IP_LSB +: IRQ_N]));
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cause_q) && $stable(count_en) && $stable(soft_irq)));
endmodule

// File: tb/cause_wr_unit_bench.sv
module cause_wr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rev2_en = 1'b0;
    logic        rev6_en = 1'b0;
    logic [31:0] cause_q;
    logic        count_en;
    logic [1:0]  soft_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model = '0;
    logic        m_cnt = 1'b1;
    logic [1:0]  m_irq = '0;

    always #5 clk = ~clk;

    cause_wr_unit u_cause_wr_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rev2_en(rev2_en), .rev6_en(rev6_en),
        .cause_q(cause_q), .count_en(count_en), .soft_irq(soft_irq)
    );

    function automatic logic [31:0] next_val(logic [31:0] old, logic [31:0] d,
                                             logic r2, logic r6);
        logic [31:0] m;
        m = 32'h00C0_0300;
        if (r2) m[27] = 1'b1;
        if (r6 && d[22]) m[22] = 1'b0;
        return (old & ~m) | (d & m);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " cause"}, cause_q, model);
        check({req, " count_en"}, {31'b0, count_en}, {31'b0, m_cnt});
        check({req, " soft_irq"}, {30'b0, soft_irq}, {30'b0, m_irq});
    endtask

    // drive at negedge, apply at posedge, check at following negedge
    task automatic do_write(logic we, logic [31:0] d, logic r2, logic r6, string req);
        logic [31:0] nv;
        wr_en = we; wr_data = d; rev2_en = r2; rev6_en = r6;
        nv = we ? next_val(model, d, r2, r6) : model;
        if (nv[27] != model[27]) m_cnt = !nv[27];
        if (nv[8] != model[8]) m_irq[0] = nv[8];
        if (nv[9] != model[9]) m_irq[1] = nv[9];
        model = nv;
        @(negedge clk);
        wr_en = 1'b0;
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int unsigned seed;
        seed = 32'd1234;
        d = $urandom(seed);
        repeat (2) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        do_write(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2 all ones base");
        check("R2 exact", cause_q, 32'h00C0_0300);
        do_write(1'b1, 32'h0000_0000, 1'b0, 1'b0, "R2 all zeros");
        do_write(1'b1, 32'h0800_0000, 1'b0, 1'b0, "R3 dc blocked");
        check("R3 dc blocked cnt", {31'b0, count_en}, 32'd1);
        do_write(1'b1, 32'h0800_0000, 1'b1, 1'b0, "R5 stop");
        check("R5 stop cnt", {31'b0, count_en}, 32'd0);
        do_write(1'b1, 32'h0800_0100, 1'b1, 1'b0, "R7 dc same");
        do_write(1'b0, 32'h0000_0000, 1'b1, 1'b0, "R8 idle");
        do_write(1'b1, 32'h0000_0100, 1'b1, 1'b0, "R5 start");
        check("R5 start cnt", {31'b0, count_en}, 32'd1);
        do_write(1'b1, 32'h0000_0200, 1'b0, 1'b0, "R6 ip swap");
        check("R6 irq", {30'b0, soft_irq}, 32'd2);
        do_write(1'b1, 32'h0040_0200, 1'b0, 1'b0, "R4 set wp via base");
        do_write(1'b1, 32'h0040_0200, 1'b0, 1'b1, "R4 wp write one");
        check("R4 wp held", {31'b0, cause_q[22]}, 32'd1);
        do_write(1'b1, 32'h0000_0200, 1'b0, 1'b1, "R4 wp clear");
        check("R4 wp cleared", {31'b0, cause_q[22]}, 32'd0);
        do_write(1'b1, 32'h0040_0000, 1'b0, 1'b1, "R4 wp no set");
        check("R4 wp still 0", {31'b0, cause_q[22]}, 32'd0);

        for (int k = 0; k < 400; k++) begin
            d = $urandom;
            if (k % 3 == 0) d = d & 32'h0AC0_0300;
            do_write(($urandom % 4) != 0, d, $urandom % 2 == 1, $urandom % 2 == 1,
                     "R2-random R3 R4 R5 R6 R7 R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule